// File: doc/BRIEF.md
# ADC Threshold-Compare Interrupt Flags

This block keeps the interrupt status of a twelve-channel analog-to-digital converter. Each cycle it may receive one finished conversion: a channel number, a 12-bit result and the low and high threshold values that apply to it. The block sorts the result against the window. It also remembers the last result seen on each channel so that it can detect when the low threshold has been crossed. Every channel has a 2-bit mode. The mode decides whether a result outside the window, a crossing, or nothing at all raises that channel's sticky threshold flag.

The same status word also shows two groups of signals it does not store. Twelve channel overrun bits and two sequence overrun bits come straight from the data-register logic outside the block. Two sticky sequence-complete flags are kept here and also drive the DMA request lines. Software reads the status word through a single read port and clears sticky bits by writing ones through a write port. Two summary interrupt lines combine the threshold flags and the overrun mirrors.

Top module: `adcthr_flag_unit`

## Requirements
- R1: With a channel's mode at 1, a conversion on that channel whose result is below the low threshold or above the high threshold sets that channel's flag (status bit = channel number, bits 11:0) at the clock edge that accepts the conversion.
- R2: With a channel's mode at 2, a conversion sets the flag when the previous result on that channel was on the other side of the current low threshold. A result equal to the low threshold counts as not below it. The first conversion on a channel after reset never counts as a crossing.
- R3: Modes 0 and 3 never set a flag. The remembered previous result is updated on every accepted conversion, whatever the mode.
- R4: Writing a 1 to status bit i (i < 12) clears threshold flag i, and writing a 0 leaves it unchanged. A flag with no write stays set. If a set and a clear reach the same flag in the same cycle, the set wins.
- R5: Reset clears every threshold flag and both sequence-complete flags, and forgets every channel's previous result.
- R6: Status bits 23:12 show the channel overrun inputs and bits 25:24 show the sequence A/B overrun inputs, combinationally. Writes to these bits have no effect.
- R7: A pulse on seq_done[j] sets sticky status bit 26+j. Writing 1 to that bit clears it, and a set wins over a same-cycle clear. dma_trig[j] equals that bit.
- R8: thr_irq is the OR of the twelve threshold flags. ovr_irq is the OR of the fourteen overrun mirrors.
- R9: Status bits 31:28 read 0 and ignore writes.
- R10: A conversion with a channel number of 12 or above changes no flag and no remembered result.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | A conversion is presented this cycle |
| conv_chan | input | 4 | Channel of the conversion |
| conv_result | input | 12 | Conversion result |
| thr_low | input | 12 | Low threshold |
| thr_high | input | 12 | High threshold |
| mode_cfg | input | 24 | Per-channel 2-bit mode, channel c in bits 2c+1:2c |
| chan_ovr_in | input | 12 | Channel overrun indications |
| seq_ovr_in | input | 2 | Sequence A/B overrun indications |
| seq_done | input | 2 | Sequence A/B complete pulses |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write data, ones clear sticky bits |
| rd_data | output | 32 | Status word |
| thr_irq | output | 1 | Threshold interrupt |
| ovr_irq | output | 1 | Overrun interrupt |
| dma_trig | output | 2 | DMA triggers from the sequence-complete flags |

## Verification
The bench targets several corner cases, each tied to a specific wrong design:
- Results exactly on either threshold. A design using inclusive comparisons would flag them wrongly in window mode.
- A result equal to the low threshold arriving after a below-threshold result. A design that tests the wrong side would miss this crossing or report one that did not happen.
- The first conversion on a channel. A design that does not track per-channel history would report a crossing against a reset value of zero.
- The reserved mode. A design that decodes only one mode bit would treat mode 3 as a live mode.
- A set and a clear in the same cycle. A design that lets the clear win would lose the event.
- Channel numbers 12 to 15. An unguarded index would alias these onto real channels or corrupt their history.

// File: rtl/adcthr_pkg.sv
package adcthr_pkg;

  typedef enum logic [1:0] {
    TM_OFF    = 2'd0,
    TM_WINDOW = 2'd1,
    TM_CROSS  = 2'd2,
    TM_RSVD   = 2'd3
  } thr_mode_e;

  function automatic logic mode_event(thr_mode_e m, logic outside, logic crossed);
    case (m)
      TM_WINDOW: mode_event = outside;
      TM_CROSS:  mode_event = crossed;
      default:   mode_event = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/adcthr_classify.sv
module adcthr_classify
  import adcthr_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic [DW-1:0] result,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] prev_result,
  input  logic          prev_valid,
  input  thr_mode_e     mode,
  output logic          hit
);
  logic below_now, above_now, below_prev, outside, crossed;

  always_comb begin
    below_now  = result < lo;
    above_now  = result > hi;
    below_prev = prev_result < lo;
    outside    = below_now | above_now;
    crossed    = prev_valid & (below_prev ^ below_now);
    hit        = mode_event(mode, outside, crossed);
  end
endmodule

// File: rtl/adcthr_history.sv
module adcthr_history #(
  parameter int NCH = 12,
  parameter int DW  = 12,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [CW-1:0] upd_ch,
  input  logic [DW-1:0] upd_val,
  output logic [DW-1:0] prev_res [NCH],
  output logic          prev_vld [NCH]
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          ch_en;
    logic [DW-1:0] res_d;
    logic          vld_d;

    always_comb begin
      ch_en = upd_en && (upd_ch == CW'(c));
      res_d = ch_en ? upd_val : prev_res[c];
      vld_d = ch_en | prev_vld[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_res[c] <= '0;
        prev_vld[c] <= 1'b0;
      end else if (ch_en) begin
        prev_res[c] <= res_d;
        prev_vld[c] <= vld_d;
      end
    end
  end
endmodule

// File: rtl/adcthr_sticky.sv
module adcthr_sticky #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         upd;

  always_comb begin
    q_d = (q & ~clr_vec) | set_vec;
    upd = (|set_vec) | (|clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_d;
  end
endmodule

// File: rtl/adcthr_flag_unit.sv
module adcthr_flag_unit
  import adcthr_pkg::*;
#(
  parameter int NCH = 12,
  parameter int DW  = 12,
  parameter int RW  = 32,
  localparam int CW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            conv_valid,
  input  logic [CW-1:0]   conv_chan,
  input  logic [DW-1:0]   conv_result,
  input  logic [DW-1:0]   thr_low,
  input  logic [DW-1:0]   thr_high,
  input  logic [2*NCH-1:0] mode_cfg,
  input  logic [NCH-1:0]  chan_ovr_in,
  input  logic [1:0]      seq_ovr_in,
  input  logic [1:0]      seq_done,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_data,
  output logic [RW-1:0]   rd_data,
  output logic            thr_irq,
  output logic            ovr_irq,
  output logic [1:0]      dma_trig
);
  localparam int OVR_LSB = NCH;
  localparam int SQO_LSB = 2 * NCH;
  localparam int SQD_LSB = 2 * NCH + 2;

  logic [1:0]    mode_arr [NCH];
  logic [DW-1:0] prev_res [NCH];
  logic          prev_vld [NCH];
  logic          ch_ok;
  logic [CW-1:0] sel_ch;
  logic          hit;
  logic [NCH-1:0] thr_set, thr_clr, thr_q;
  logic [1:0]     sqd_clr, sqd_q;

  for (genvar c = 0; c < NCH; c++) begin : g_mode
    assign mode_arr[c] = mode_cfg[2*c +: 2];
  end

  always_comb begin
    ch_ok  = conv_valid && (int'(conv_chan) < NCH);
    sel_ch = ch_ok ? conv_chan : '0;
  end

  adcthr_classify #(.DW(DW)) u_cls (
    .result      (conv_result),
    .lo          (thr_low),
    .hi          (thr_high),
    .prev_result (prev_res[sel_ch]),
    .prev_valid  (prev_vld[sel_ch]),
    .mode        (thr_mode_e'(mode_arr[sel_ch])),
    .hit         (hit)
  );

  adcthr_history #(.NCH(NCH), .DW(DW)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (ch_ok),
    .upd_ch   (sel_ch),
    .upd_val  (conv_result),
    .prev_res (prev_res),
    .prev_vld (prev_vld)
  );

  always_comb begin
    thr_set = '0;
    if (ch_ok && hit) thr_set[sel_ch] = 1'b1;
    thr_clr = wr_en ? wr_data[NCH-1:0] : '0;
    sqd_clr = wr_en ? wr_data[SQD_LSB +: 2] : 2'b00;
  end

  adcthr_sticky #(.W(NCH)) u_thr (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (thr_set),
    .clr_vec (thr_clr),
    .q       (thr_q)
  );

  adcthr_sticky #(.W(2)) u_sqd (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (seq_done),
    .clr_vec (sqd_clr),
    .q       (sqd_q)
  );

  always_comb begin
    rd_data                   = '0;
    rd_data[NCH-1:0]          = thr_q;
    rd_data[OVR_LSB +: NCH]   = chan_ovr_in;
    rd_data[SQO_LSB +: 2]     = seq_ovr_in;
    rd_data[SQD_LSB +: 2]     = sqd_q;
    thr_irq  = |thr_q;
    ovr_irq  = (|chan_ovr_in) | (|seq_ovr_in);
    dma_trig = sqd_q;
  end
endmodule

// File: rtl/adcthr_flag_unit_chk.sv
module adcthr_flag_unit_chk #(
  parameter int NCH = 12,
  parameter int DW  = 12,
  parameter int RW  = 32,
  localparam int CW = $clog2(NCH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_valid,
  input logic [CW-1:0]    conv_chan,
  input logic [2*NCH-1:0] mode_cfg,
  input logic [1:0]       seq_done,
  input logic             wr_en,
  input logic [RW-1:0]    wr_data,
  input logic [RW-1:0]    rd_data,
  input logic             thr_irq,
  input logic [1:0]       dma_trig
);
  localparam int SQD_LSB = 2 * NCH + 2;
  localparam int USED    = 2 * NCH + 4;

  for (genvar i = 0; i < NCH; i++) begin : g_flag
    a_r3_set_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rd_data[i]) && rd_data[i]) |->
        $past(conv_valid && conv_chan == CW'(i) &&
              (mode_cfg[2*i +: 2] == 2'd1 || mode_cfg[2*i +: 2] == 2'd2)));
    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_data[i]) && !$past(wr_en && wr_data[i])) |-> rd_data[i]);
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && wr_data[i] && !(conv_valid && conv_chan == CW'(i))) |-> !rd_data[i]);
  end

  for (genvar j = 0; j < 2; j++) begin : g_seq
    a_r7_seq_set: assert property (@(posedge clk) disable iff (!rst_n)
      $past(seq_done[j]) |-> (rd_data[SQD_LSB + j] && dma_trig[j]));
  end

  a_r8_thr_irq: assert property (@(posedge clk) disable iff (!rst_n)
    thr_irq == (rd_data[NCH-1:0] != '0));

  if (USED < RW) begin : g_rsvd
    a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[RW-1:USED] == '0);
  end
endmodule

bind adcthr_flag_unit adcthr_flag_unit_chk #(.NCH(NCH), .DW(DW), .RW(RW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_valid (conv_valid),
  .conv_chan  (conv_chan),
  .mode_cfg   (mode_cfg),
  .seq_done   (seq_done),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .thr_irq    (thr_irq),
  .dma_trig   (dma_trig)
);

// File: tb/adcthr_flag_unit_tb_top.sv
module adcthr_flag_unit_tb_top;
  logic        clk, rst_n;
  logic        conv_valid;
  logic [3:0]  conv_chan;
  logic [11:0] conv_result, thr_low, thr_high;
  logic [23:0] mode_cfg;
  logic [11:0] chan_ovr_in;
  logic [1:0]  seq_ovr_in, seq_done;
  logic        wr_en;
  logic [31:0] wr_data, rd_data;
  logic        thr_irq, ovr_irq;
  logic [1:0]  dma_trig;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [11:0] m_thr;
  logic [1:0]  m_sqd;
  logic [11:0] m_prev [12];
  logic        m_pv [12];

  adcthr_flag_unit dut_i (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    return {4'b0, m_sqd, seq_ovr_in, chan_ovr_in, m_thr};
  endfunction

  task automatic cycle(input logic cv, input int ch, input logic [11:0] r,
                       input logic we, input logic [31:0] wd, input logic [1:0] sd);
    logic [11:0] setv;
    logic [1:0]  md;
    logic        below, oor, crs, hitv;
    @(negedge clk);
    conv_valid = cv; conv_chan = 4'(ch); conv_result = r;
    wr_en = we; wr_data = wd; seq_done = sd;
    setv = '0;
    if (cv && ch < 12) begin
      md    = mode_cfg[2*ch +: 2];
      below = r < thr_low;
      oor   = below || (r > thr_high);
      crs   = m_pv[ch] && ((m_prev[ch] < thr_low) != below);
      hitv  = (md == 2'd1) ? oor : (md == 2'd2) ? crs : 1'b0;
      setv[ch] = hitv;
      m_prev[ch] = r;
      m_pv[ch] = 1'b1;
    end
    @(posedge clk);
    m_thr = (m_thr & ~(we ? wd[11:0] : 12'h0)) | setv;
    m_sqd = (m_sqd & ~(we ? wd[27:26] : 2'b00)) | sd;
    @(negedge clk);
    conv_valid = 0; wr_en = 0; wr_data = '0; seq_done = '0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] vals [10];
    vals = '{12'd150, 12'd50, 12'd120, 12'd99, 12'd100, 12'd251, 12'd250, 12'd4095, 12'd0, 12'd260};
    rst_n = 0; conv_valid = 0; conv_chan = 0; conv_result = 0;
    thr_low = 12'd100; thr_high = 12'd250; mode_cfg = '0;
    chan_ovr_in = '0; seq_ovr_in = '0; seq_done = '0; wr_en = 0; wr_data = '0;
    m_thr = '0; m_sqd = '0;
    for (int c = 0; c < 12; c++) begin m_prev[c] = '0; m_pv[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R5 reset status", rd_data, 32'h0);
    chk("R5 reset dma", {30'b0, dma_trig}, 32'h0);

    // R1 R2 R3 sweep: every channel, rotating modes, boundary values
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 12; c++) mode_cfg[2*c +: 2] = 2'((m + c) % 4);
      cycle(0, 0, 0, 1, 32'hFFFF_FFFF, 2'b00);
      chk("R4 clear all", rd_data, exp_word());
      for (int v = 0; v < 10; v++) begin
        for (int c = 0; c < 12; c++) begin
          cycle(1, c, vals[v], 0, 0, 2'b00);
          chk("R1 R2 R3 classify", rd_data, exp_word());
          chk("R8 thr_irq", {31'b0, thr_irq}, {31'b0, m_thr != 0});
        end
      end
    end

    // R10 out-of-range channel numbers
    mode_cfg = {12{2'd1}};
    cycle(0, 0, 0, 1, 32'hFFF, 2'b00);
    for (int c = 12; c < 16; c++) begin
      cycle(1, c, 12'd0, 0, 0, 2'b00);
      chk("R10 bad channel ignored", rd_data, 32'h0);
    end
    mode_cfg = {12{2'd2}};
    cycle(1, 5, 12'd200, 0, 0, 2'b00);
    cycle(1, 13, 12'd10, 0, 0, 2'b00);
    cycle(1, 5, 12'd210, 0, 0, 2'b00);
    chk("R10 history untouched", rd_data, exp_word());

    // R4 write-one-to-clear patterns and set-wins
    mode_cfg = {12{2'd1}};
    for (int c = 0; c < 12; c++) cycle(1, c, 12'd0, 0, 0, 2'b00);
    chk("R4 all set", rd_data, 32'hFFF);
    cycle(0, 0, 0, 1, 32'h0000_0A5A, 2'b00);
    chk("R4 partial clear", rd_data, 32'h5A5);
    cycle(0, 0, 0, 1, 32'h0, 2'b00);
    chk("R4 write zero", rd_data, 32'h5A5);
    cycle(1, 3, 12'd300, 1, 32'h0000_0008 | 32'h0000_0001, 2'b00);
    chk("R4 set wins", rd_data, exp_word());
    chk("R4 set wins bit3", {31'b0, rd_data[3]}, 32'h1);

    // R6 R8 overrun mirrors, walking one
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      {seq_ovr_in, chan_ovr_in} = 14'(1 << i);
      #1;
      chk("R6 ovr mirror", rd_data, exp_word());
      chk("R8 ovr_irq", {31'b0, ovr_irq}, 32'h1);
    end
    @(negedge clk); {seq_ovr_in, chan_ovr_in} = '0; #1;
    chk("R8 ovr_irq low", {31'b0, ovr_irq}, 32'h0);
    chan_ovr_in = 12'h3C3; seq_ovr_in = 2'b10;
    cycle(0, 0, 0, 1, 32'h03FF_F000, 2'b00);
    chk("R6 write ignored", rd_data, exp_word());
    chan_ovr_in = '0; seq_ovr_in = '0;

    // R7 sequence-complete flags and DMA triggers
    cycle(0, 0, 0, 0, 0, 2'b01);
    chk("R7 seqA set", rd_data, exp_word());
    chk("R7 dma", {30'b0, dma_trig}, 32'h1);
    cycle(0, 0, 0, 1, 32'h0800_0000, 2'b10);
    chk("R7 set wins", {30'b0, dma_trig}, 32'h3);
    cycle(0, 0, 0, 1, 32'h0400_0000, 2'b00);
    chk("R7 clear A", {30'b0, dma_trig}, 32'h2);

    // R9 reserved bits
    cycle(0, 0, 0, 1, 32'hFFFF_FFFF, 2'b00);
    chk("R9 reserved zero", rd_data, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule